// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block translates the addresses of requests that leave an on-chip bus toward a PCIe link. A fixed bus offset is first removed from each 64-bit request address. The result is compared against a small set of outbound windows, two by default, that all share one window size. A window that contains the adjusted address turns it into a PCIe address: the window's 64-bit remap value plus the request's offset inside the window.

A 32-bit register write port programs each window's base and remap values. The request port takes a request with its address and, one cycle later, reports either a hit, with the translated address and the index of the matching window, or a miss, which raises an error flag. A region larger than one window is covered by programming consecutive windows whose base and remap values each advance by one window size.

Top module: `obxlat_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every response output is zero. Reset clears all windows to invalid, so a request presented right after reset misses.
- R2: The write port is byte addressed. For window i the registers sit at: base bits 31:0 at 0x00+8*i, base bits 63:32 at 0x04+8*i, remap bits 31:0 at 0x10+8*i, remap bits 63:32 at 0x14+8*i. A write to any other address (for example 0x20, 0x3C or a non-word-aligned 0x02) changes no window.
- R3: Bit 0 of a window's base bits 31:0 is its valid flag. A window whose valid flag is 0 never hits.
- R4: Bit 1 of the base (the size-configuration flag) and every other base bit below the window size have no effect on matching. Bases are aligned to the window size of 2^WIN_LOG2 bytes (64 KiB by default).
- R5: BUS_OFFSET (0x4000_0000 by default) is subtracted from the request address before matching. A request address below BUS_OFFSET always misses.
- R6: On a hit, the translated address is the remap value of the window plus the adjusted address modulo the window size. rsp_win gives the index of the window.
- R7: When more than one valid window contains the adjusted address, the window with the lowest index wins.
- R8: On a response, exactly one of rsp_hit and rsp_miss is high. On a miss, rsp_addr and rsp_win are zero.
- R9: rsp_valid is high exactly in the cycle after a cycle with req_valid high. When rsp_valid is low, rsp_hit and rsp_miss are low.
- R10: A register write and a request in the same cycle: the request is translated with the window contents from before the write. The write takes effect from the next request on.
- R11: Two windows programmed back to back, with base and remap each advanced by one window size, translate a contiguous region linearly across the window boundary. This also holds when the base bits 63:32 are non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register byte address |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | Bus address of the request |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_hit | output | 1 | Request matched a window |
| rsp_miss | output | 1 | Request matched no window (error) |
| rsp_win | output | clog2(NUM_WIN) | Index of the matching window |
| rsp_addr | output | 64 | Translated PCIe address, zero on a miss |

## Verification
A register write and a request can land in the same cycle, and the block must then translate with the window contents from before the write. The bench provokes this in two ways. It clears the valid flag of the window a request is about to hit, in the same cycle as that request. It also rewrites a remap word under a live request. The expected response comes from a behavioural model that evaluates each request before it applies that cycle's write. The next request must then show the new contents.

// File: rtl/obxlat_pkg.sv
package obxlat_pkg;

    localparam int ADDR_W = 64;
    localparam int WORD_W = 32;

    // Which half-word of which register a write targets
    typedef enum logic [1:0] {
        FLD_BASE_LO  = 2'b00,
        FLD_BASE_HI  = 2'b01,
        FLD_REMAP_LO = 2'b10,
        FLD_REMAP_HI = 2'b11
    } fld_e;

endpackage

// File: rtl/obxlat_regs.sv
module obxlat_regs
    import obxlat_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int REG_AW  = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [REG_AW-1:0]               wr_addr,
    input  logic [WORD_W-1:0]               wr_data,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  base_q,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  remap_q
);
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int GRP_BIT = IDX_W + 3;

    logic [IDX_W-1:0] sel_idx;
    fld_e             sel_fld;
    logic             legal;

    assign sel_idx = wr_addr[GRP_BIT-1:3];
    assign sel_fld = fld_e'({wr_addr[GRP_BIT], wr_addr[2]});
    assign legal   = wr_en && (wr_addr[1:0] == 2'b00)
                   && ((wr_addr >> (GRP_BIT + 1)) == '0)
                   && (int'(sel_idx) < NUM_WIN);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[i]  <= '0;
                remap_q[i] <= '0;
            end else if (legal && sel_idx == IDX_W'(i)) begin
                unique case (sel_fld)
                    FLD_BASE_LO:  base_q[i][31:0]   <= wr_data;
                    FLD_BASE_HI:  base_q[i][63:32]  <= wr_data;
                    FLD_REMAP_LO: remap_q[i][31:0]  <= wr_data;
                    FLD_REMAP_HI: remap_q[i][63:32] <= wr_data;
                endcase
            end
        end
    end

    AST_BASE0_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_AW'(0)) |=> base_q[0][31:0] == $past(wr_data)); // R2

    AST_ODD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[1:0] != 2'b00) |=> ($stable(base_q) && $stable(remap_q))); // R2

endmodule

// File: rtl/obxlat_match.sv
module obxlat_match
    import obxlat_pkg::*;
#(
    parameter int              NUM_WIN    = 2,
    parameter int              WIN_LOG2   = 16,
    parameter logic [63:0]     BUS_OFFSET = 64'h0000_0000_4000_0000
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  base,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  remap,
    output logic                            hit,
    output logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] win,
    output logic [ADDR_W-1:0]               xaddr
);
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic               below;
    logic [ADDR_W-1:0]  adj;
    logic [NUM_WIN-1:0] hit_vec;

    assign below = addr < BUS_OFFSET;
    assign adj   = addr - BUS_OFFSET;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        assign hit_vec[i] = base[i][0] && !below
                          && (adj[ADDR_W-1:WIN_LOG2] == base[i][ADDR_W-1:WIN_LOG2]);
    end

    // Lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit = 1'b0;
        win = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit = 1'b1;
                win = IDX_W'(i);
            end
        end
    end

    assign xaddr = remap[win] + {{(ADDR_W - WIN_LOG2){1'b0}}, adj[WIN_LOG2-1:0]};

endmodule

// File: rtl/obxlat_top.sv
module obxlat_top
    import obxlat_pkg::*;
#(
    parameter int          NUM_WIN    = 2,
    parameter int          WIN_LOG2   = 16,
    parameter logic [63:0] BUS_OFFSET = 64'h0000_0000_4000_0000,
    parameter int          REG_AW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] rsp_win,
    output logic [63:0]       rsp_addr
);
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] remap_q;
    logic                           m_hit;
    logic [IDX_W-1:0]               m_win;
    logic [ADDR_W-1:0]              m_xaddr;

    obxlat_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .base_q(base_q), .remap_q(remap_q)
    );

    obxlat_match #(.NUM_WIN(NUM_WIN), .WIN_LOG2(WIN_LOG2), .BUS_OFFSET(BUS_OFFSET)) u_match (
        .addr(req_addr), .base(base_q), .remap(remap_q),
        .hit(m_hit), .win(m_win), .xaddr(m_xaddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_win   <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && m_hit;
            rsp_miss  <= req_valid && !m_hit;
            rsp_win   <= (req_valid && m_hit) ? m_win : '0;
            rsp_addr  <= (req_valid && m_hit) ? m_xaddr : '0;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss)); // R8

    AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_addr == '0 && rsp_win == '0)); // R8

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R9

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss)); // R9

    AST_BELOW_OFFSET_MISS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr < BUS_OFFSET) |=> rsp_miss); // R5

endmodule

// File: tb/obxlat_top_tb.sv
module obxlat_top_tb;
    localparam logic [63:0] OFF = 64'h0000_0000_4000_0000;
    localparam logic [63:0] WS  = 64'h0000_0000_0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [0:0]  rsp_win;
    logic [63:0] rsp_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    obxlat_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_win(rsp_win), .rsp_addr(rsp_addr)
    );

    // Behavioural reference: window contents and expected response
    logic [63:0] mb [2];
    logic [63:0] mr [2];
    logic        e_v, e_hit, e_miss;
    int          e_win;
    logic [63:0] e_addr;
    string       e_tag;

    always @(posedge clk) begin
        logic [63:0] d, lo;
        if (rst) begin
            for (int i = 0; i < 2; i++) begin mb[i] = '0; mr[i] = '0; end
            e_v = 0; e_hit = 0; e_miss = 0; e_win = 0; e_addr = '0; e_tag = "R1";
        end else begin
            e_v = req_valid; e_hit = 0; e_win = 0; e_addr = '0; e_tag = cur_tag;
            if (req_valid && req_addr >= OFF) begin
                d = req_addr - OFF;
                for (int i = 1; i >= 0; i--) begin
                    lo = mb[i] & ~(WS - 1);
                    if (mb[i][0] && d >= lo && d < lo + WS) begin
                        e_hit = 1; e_win = i; e_addr = mr[i] + (d - lo);
                    end
                end
            end
            e_miss = req_valid && !e_hit;
            if (wr_en) begin
                case (wr_addr)
                    8'h00: mb[0][31:0]  = wr_data;
                    8'h04: mb[0][63:32] = wr_data;
                    8'h08: mb[1][31:0]  = wr_data;
                    8'h0C: mb[1][63:32] = wr_data;
                    8'h10: mr[0][31:0]  = wr_data;
                    8'h14: mr[0][63:32] = wr_data;
                    8'h18: mr[1][31:0]  = wr_data;
                    8'h1C: mr[1][63:32] = wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(e_tag, "rsp_valid", 64'(rsp_valid), 64'(e_v));
            chk(e_tag, "rsp_hit",   64'(rsp_hit),   64'(e_hit));
            chk(e_tag, "rsp_miss",  64'(rsp_miss),  64'(e_miss));
            chk(e_tag, "rsp_win",   64'(rsp_win),   64'(e_win));
            chk(e_tag, "rsp_addr",  rsp_addr,       e_addr);
        end
    end

    task automatic step(string tag, bit we, logic [7:0] wa, logic [31:0] wd,
                        bit rv, logic [63:0] ra);
        @(negedge clk);
        cur_tag = tag;
        wr_en = we; wr_addr = wa; wr_data = wd;
        req_valid = rv; req_addr = ra;
    endtask

    task automatic wr(string tag, logic [7:0] wa, logic [31:0] wd);
        step(tag, 1, wa, wd, 0, '0);
    endtask

    task automatic rq(string tag, logic [63:0] ra);
        step(tag, 0, '0, '0, 1, ra);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rq("R1", 64'h4000_0000);
        step("R1", 0, '0, '0, 0, '0);
        // Writes to unused or misaligned addresses
        wr("R2", 8'h20, 32'h0000_0001);
        wr("R2", 8'h3C, 32'h0000_0001);
        wr("R2", 8'h02, 32'h0000_0001);
        rq("R2", 64'h4000_0000);
        // Valid flag
        wr("R3", 8'h00, 32'h0010_0000);
        wr("R3", 8'h10, 32'h8000_0000);
        wr("R3", 8'h14, 32'h0000_0012);
        rq("R3", 64'h4010_0000);
        wr("R3", 8'h00, 32'h0010_0001);
        rq("R3", 64'h4010_0000);
        // Low base bits, including the size flag, ignored
        wr("R4", 8'h00, 32'h0010_1233);
        rq("R4", 64'h4010_0004);
        rq("R4", 64'h4010_FFFF);
        rq("R4", 64'h4011_0000);
        // Offset removal
        wr("R5", 8'h08, 32'h0000_0001);
        rq("R5", 64'h0010_0000);
        rq("R5", 64'h3FFF_FFFF);
        rq("R5", 64'h4000_0010);
        // Translation
        rq("R6", 64'h4010_ABCD);
        rq("R6", 64'h4010_0000);
        // Overlap: lower index wins
        wr("R7", 8'h08, 32'h0010_0001);
        wr("R7", 8'h18, 32'h0BAD_0000);
        rq("R7", 64'h4010_1234);
        // Miss outputs zeroed
        rq("R8", 64'h7000_0000);
        step("R9", 0, '0, '0, 0, '0);
        rq("R9", 64'h4010_0001);
        // Write and request in the same cycle
        step("R10", 1, 8'h00, 32'h0010_0000, 1, 64'h4010_0020);
        rq("R10", 64'h4010_0020);
        step("R10", 1, 8'h18, 32'h0C0D_0000, 1, 64'h4010_0030);
        rq("R10", 64'h4010_0030);
        // Contiguous region over both windows
        wr("R11", 8'h00, 32'h0020_0001);
        wr("R11", 8'h04, 32'h0000_0001);
        wr("R11", 8'h10, 32'h0000_0000);
        wr("R11", 8'h14, 32'h0000_0080);
        wr("R11", 8'h08, 32'h0021_0001);
        wr("R11", 8'h0C, 32'h0000_0001);
        wr("R11", 8'h18, 32'h0001_0000);
        wr("R11", 8'h1C, 32'h0000_0080);
        rq("R11", 64'h1_4020_0000);
        rq("R11", 64'h1_4020_FFFC);
        rq("R11", 64'h1_4021_0000);
        rq("R11", 64'h1_4021_FFFF);
        rq("R11", 64'h1_4022_0000);
        rq("R11", 64'h0_4020_0000);
        step("R9", 0, '0, '0, 0, '0);
        step("R9", 0, '0, '0, 0, '0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule